// File: doc/BRIEF.md
# Multi-channel FIFO read port

This block is the read side of a buffer that keeps several independent first-in first-out channels in one shared storage array. Each channel has its own read pointer, write pointer and occupancy counter. A pipelined bus master reads from it over a request/acknowledge handshake. The master puts a channel number on `ch_sel_i` and waits for `ch_valid_o`. It then raises `req_i`, together with two qualifiers: `burst_i` (a fixed-length burst rather than one beat) and `stat_i` (a status read rather than a data read).

The kind of transfer is taken from the qualifiers only in the cycle where a transfer starts. A master that lowers its request several cycles late therefore gets no extra words. A status read returns the selected channel's flags and occupancy for every cycle the request is held. A data read on an empty channel answers with `err_ack_o` and leaves the channel untouched. A minimal write port (`wr_*`) fills the channels. Writes to a full channel are dropped.

Top module: `cfifo_rd_port`

## Requirements
- R1: After reset, `ack_o` and `err_ack_o` are low, `rdata_o` is zero and every channel is empty.
- R2: In a cycle where `ch_sel_i` differs from the value it had at the previous clock edge, `ch_valid_o` is low and a request is not started. `ch_valid_o` is high from the next clock onward while `ch_sel_i` stays stable.
- R3: A data request that starts with `burst_i` low pops exactly one word and gives one `ack_o` pulse. The pulse comes in the cycle after the request is first sampled, with the word on `rdata_o`, however long the request stays high afterwards.
- R4: A data request that starts with `burst_i` high pops BURST_LEN words (default 4). It acknowledges them on consecutive cycles, in write order, starting the cycle after the request is sampled.
- R5: A request that starts with `stat_i` high pops nothing. It gives one `ack_o` cycle, one clock later, for each clock edge at which `req_i` is high.
- R6: A status word has three flags and a count:
  - bit DWIDTH-1 is Empty (occupancy 0);
  - bit DWIDTH-2 is AlmostEmpty (occupancy at most 1);
  - bit DWIDTH-3 is HalfEmpty (occupancy at most DEPTH/2);
  - bits DWIDTH-4 down to DWIDTH-32 hold the occupancy, right-justified;
  - all lower bits are zero.
- R7: A data request on an empty channel gives `err_ack_o` in place of `ack_o` and leaves that channel's pointers and count unchanged. A burst that finds the channel empty part-way ends with one `err_ack_o` after the words it delivered.
- R8: A new transfer starts only after `req_i` has been seen low since the previous start.
- R9: Channels are independent. Reading one channel never changes another channel's count or order.
- R10: A write with `wr_en_i` stores `wr_data_i` into channel `wr_ch_i`. The write is dropped when that channel holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel_i | input | CHW | Channel chosen for reading |
| ch_valid_o | output | 1 | Selected channel is active and its status is valid |
| req_i | input | 1 | Transfer request |
| burst_i | input | 1 | Burst qualifier, taken when a transfer starts |
| stat_i | input | 1 | Status-read qualifier, taken when a transfer starts |
| ack_o | output | 1 | Word or status delivered on `rdata_o` |
| err_ack_o | output | 1 | Data read refused, channel empty |
| rdata_o | output | DWIDTH | Read data or status word |
| wr_en_i | input | 1 | Write strobe |
| wr_ch_i | input | CHW | Channel to write |
| wr_data_i | input | DWIDTH | Word to write |

## Verification
A wrong pointer or counter in one channel shows on the next status read of that channel as a bad occupancy field or flag, one cycle after the request. It also shows on the next data read as a word out of write order. A fault in the start logic shows at once as a missing or extra `ack_o` pulse when the request is held late. The bench also counts pulses across a burst and checks that nothing follows them. Reads from one channel are interleaved with status reads of another, so crosstalk between channels appears as a count change one cycle after the probing request.

// File: rtl/cfifo_rd_pkg.sv
package cfifo_rd_pkg;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_BURST,
        XS_STATUS
    } xfer_state_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
        logic half_empty;
    } chan_flags_t;

    function automatic chan_flags_t flags_of(input int unsigned occ, input int unsigned depth);
        chan_flags_t f;
        f.empty        = (occ == 0);
        f.almost_empty = (occ <= 1);
        f.half_empty   = (occ <= depth / 2);
        return f;
    endfunction

    function automatic logic [31:0] pack_status(input chan_flags_t f, input int unsigned occ);
        return {f.empty, f.almost_empty, f.half_empty, 29'(occ)};
    endfunction

endpackage

// File: rtl/cfifo_chan_ctrl.sv
module cfifo_chan_ctrl #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [PW-1:0] rptr_o,
    output logic [PW-1:0] wptr_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic push_ok;

    assign full_o  = (count_o == CW'(DEPTH));
    assign empty_o = (count_o == '0);
    assign push_ok = push_i && !full_o;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_o  <= '0;
            wptr_o  <= '0;
            count_o <= '0;
        end else begin
            if (push_ok) wptr_o <= bump(wptr_o);
            if (pop_i)   rptr_o <= bump(rptr_o);
            if (push_ok && !pop_i)      count_o <= count_o + 1'b1;
            else if (pop_i && !push_ok) count_o <= count_o - 1'b1;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count_o <= CW'(DEPTH)); // R10
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (count_o != '0)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && count_o == CW'(DEPTH)) |=> (count_o == CW'(DEPTH))); // R10

endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 8,
    parameter int DWIDTH = 64,
    localparam int AW = $clog2(NUM_CH * DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DWIDTH-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DWIDTH-1:0] rdata_o
);
    logic [DWIDTH-1:0] mem [NUM_CH * DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/cfifo_xfer_seq.sv
module cfifo_xfer_seq
    import cfifo_rd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    localparam int LW = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic burst_i,
    input  logic stat_i,
    input  logic chv_i,
    input  logic empty_i,
    output logic pop_o,
    output logic stat_ld_o,
    output logic ack_o,
    output logic err_o
);
    xfer_state_t state_q, state_n;
    logic [LW-1:0] left_q, left_n;
    logic armed_q, start, err_now, single_q;

    always_comb begin
        state_n   = state_q;
        left_n    = left_q;
        pop_o     = 1'b0;
        stat_ld_o = 1'b0;
        err_now   = 1'b0;
        start     = 1'b0;
        case (state_q)
            XS_IDLE: begin
                if (req_i && armed_q && chv_i) begin
                    start = 1'b1;
                    if (stat_i) begin
                        stat_ld_o = 1'b1;
                        state_n   = XS_STATUS;
                    end else if (empty_i) begin
                        err_now = 1'b1;
                    end else begin
                        pop_o = 1'b1;
                        if (burst_i && BURST_LEN > 1) begin
                            state_n = XS_BURST;
                            left_n  = LW'(BURST_LEN - 1);
                        end
                    end
                end
            end
            XS_BURST: begin
                if (empty_i) begin
                    err_now = 1'b1;
                    state_n = XS_IDLE;
                end else begin
                    pop_o  = 1'b1;
                    left_n = left_q - 1'b1;
                    if (left_q == LW'(1)) state_n = XS_IDLE;
                end
            end
            XS_STATUS: begin
                if (req_i) stat_ld_o = 1'b1;
                else       state_n   = XS_IDLE;
            end
            default: state_n = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= XS_IDLE;
            left_q   <= '0;
            armed_q  <= 1'b0;
            ack_o    <= 1'b0;
            err_o    <= 1'b0;
            single_q <= 1'b0;
        end else begin
            state_q  <= state_n;
            left_q   <= left_n;
            ack_o    <= pop_o || stat_ld_o;
            err_o    <= err_now;
            single_q <= start && !stat_i && !burst_i;
            if (!req_i)     armed_q <= 1'b1;
            else if (start) armed_q <= 1'b0;
        end
    end

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack_o && err_o)); // R7
    AST_SINGLE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (ack_o && single_q) |=> !ack_o); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_IDLE && !armed_q && req_i) |=> (!ack_o && !err_o)); // R8
    AST_BURST_COUNT: assert property (@(posedge clk) disable iff (rst)
        left_q <= LW'(BURST_LEN)); // R4
    AST_STAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_STATUS && req_i) |=> ack_o); // R5

endmodule

// File: rtl/cfifo_rd_port.sv
module cfifo_rd_port
    import cfifo_rd_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DEPTH     = 8,
    parameter int DWIDTH    = 64,
    parameter int BURST_LEN = 4,
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PW  = $clog2(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int AW  = $clog2(NUM_CH * DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHW-1:0]    ch_sel_i,
    output logic              ch_valid_o,
    input  logic              req_i,
    input  logic              burst_i,
    input  logic              stat_i,
    output logic              ack_o,
    output logic              err_ack_o,
    output logic [DWIDTH-1:0] rdata_o,
    input  logic              wr_en_i,
    input  logic [CHW-1:0]    wr_ch_i,
    input  logic [DWIDTH-1:0] wr_data_i
);
    logic [CHW-1:0]    ch_q;
    logic [PW-1:0]     rptr  [NUM_CH];
    logic [PW-1:0]     wptr  [NUM_CH];
    logic [CW-1:0]     cnt   [NUM_CH];
    logic [NUM_CH-1:0] full, empty;
    logic              seq_pop, stat_ld;
    logic [DWIDTH-1:0] mem_rdata, stat_word;
    logic [AW-1:0]     waddr, raddr;
    chan_flags_t       sel_flags;

    function automatic logic [AW-1:0] addr_of(input logic [CHW-1:0] ch, input logic [PW-1:0] p);
        return AW'(ch) * AW'(DEPTH) + AW'(p);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_sel_i;
    end
    assign ch_valid_o = (ch_q == ch_sel_i);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        cfifo_chan_ctrl #(.DEPTH(DEPTH)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .push_i  (wr_en_i && (wr_ch_i == CHW'(g))),
            .pop_i   (seq_pop && (ch_q == CHW'(g))),
            .rptr_o  (rptr[g]),
            .wptr_o  (wptr[g]),
            .count_o (cnt[g]),
            .full_o  (full[g]),
            .empty_o (empty[g])
        );
    end

    assign waddr = addr_of(wr_ch_i, wptr[wr_ch_i]);
    assign raddr = addr_of(ch_q, rptr[ch_q]);

    cfifo_store #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DWIDTH(DWIDTH)) store_i (
        .clk     (clk),
        .we_i    (wr_en_i && !full[wr_ch_i]),
        .waddr_i (waddr),
        .wdata_i (wr_data_i),
        .raddr_i (raddr),
        .rdata_o (mem_rdata)
    );

    cfifo_xfer_seq #(.BURST_LEN(BURST_LEN)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .burst_i   (burst_i),
        .stat_i    (stat_i),
        .chv_i     (ch_valid_o),
        .empty_i   (empty[ch_q]),
        .pop_o     (seq_pop),
        .stat_ld_o (stat_ld),
        .ack_o     (ack_o),
        .err_o     (err_ack_o)
    );

    always_comb begin
        sel_flags = flags_of(int'(cnt[ch_q]), DEPTH);
        stat_word = '0;
        stat_word[DWIDTH-1 -: 32] = pack_status(sel_flags, int'(cnt[ch_q]));
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_o <= '0;
        else if (seq_pop) rdata_o <= mem_rdata;
        else if (stat_ld) rdata_o <= stat_word;
    end

    AST_CHV_DROP: assert property (@(posedge clk) disable iff (rst)
        (ch_sel_i != $past(ch_sel_i)) |-> !ch_valid_o); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ack_o && !$past(rst)) |-> $stable(rdata_o)); // R3

endmodule

// File: tb/cfifo_rd_port_tb_top.sv
module cfifo_rd_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DEP = 8;
    localparam int DW  = 64;
    localparam int BL  = 4;

    logic clk = 0, rst = 1;
    logic [1:0] ch_sel = 0, wr_ch = 0;
    logic req = 0, burst = 0, stat = 0, wr_en = 0;
    logic [DW-1:0] wr_data = 0;
    logic ch_valid, ack, err_ack;
    logic [DW-1:0] rdata;

    int total = 0, bad = 0;
    int head [NCH];
    int tail [NCH];
    int n_ack, n_err, first_i, last_i;
    logic [DW-1:0] cap [16];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfifo_rd_port #(.NUM_CH(NCH), .DEPTH(DEP), .DWIDTH(DW), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst(rst), .ch_sel_i(ch_sel), .ch_valid_o(ch_valid),
        .req_i(req), .burst_i(burst), .stat_i(stat), .ack_o(ack),
        .err_ack_o(err_ack), .rdata_o(rdata), .wr_en_i(wr_en),
        .wr_ch_i(wr_ch), .wr_data_i(wr_data)
    );

    function automatic logic [DW-1:0] mkdata(input int ch, input int n);
        return {8'(ch), 24'(n), 32'hA500_0000 | 32'(n)};
    endfunction

    function automatic logic [DW-1:0] exp_stat(input int occ);
        return {occ == 0, occ <= 1, occ <= DEP/2, 29'(occ), 32'h0};
    endfunction

    task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic push(input int ch);
        @(negedge clk);
        wr_en = 1; wr_ch = 2'(ch); wr_data = mkdata(ch, tail[ch]);
        if (tail[ch] - head[ch] < DEP) tail[ch]++;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic select(input int ch);
        @(negedge clk);
        ch_sel = 2'(ch);
        @(negedge clk);
    endtask

    task automatic run_req(input int hold, input logic b, input logic s);
        @(negedge clk);
        req = 1; burst = b; stat = s;
        n_ack = 0; n_err = 0; first_i = -1; last_i = -1;
        for (int i = 0; i < hold + BL + 3; i++) begin
            @(negedge clk);
            if (ack) begin
                if (n_ack < 16) cap[n_ack] = rdata;
                n_ack++;
                if (first_i < 0) first_i = i;
                last_i = i;
            end
            if (err_ack) n_err++;
            if (i == hold - 1) begin req = 0; burst = 0; stat = 0; end
        end
    endtask

    task automatic probe_status(input string r, input int ch);
        select(ch);
        run_req(1, 0, 1);
        check({r, " status ack count"}, 64'(n_ack), 64'd1);
        check({r, " status word"}, cap[0], exp_stat(tail[ch] - head[ch]));
    endtask

    task automatic t_reset;
        check("R1 ack", 64'(ack), 64'd0);
        check("R1 err_ack", 64'(err_ack), 64'd0);
        check("R1 rdata", rdata, 64'd0);
        probe_status("R1", 0);
    endtask

    task automatic t_chan_valid;
        @(negedge clk);
        ch_sel = 2;
        #1 check("R2 valid low on change", 64'(ch_valid), 64'd0);
        @(negedge clk);
        check("R2 valid high after", 64'(ch_valid), 64'd1);
        @(negedge clk);
        ch_sel = 3; req = 1; stat = 1;
        n_ack = 0;
        @(negedge clk);
        if (ack) n_ack++;
        req = 0; stat = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (ack || err_ack) n_ack++;
        end
        check("R2 no start while invalid", 64'(n_ack), 64'd0);
    endtask

    task automatic t_status;
        for (int k = 0; k < 3; k++) push(1);
        select(1);
        run_req(3, 0, 1);
        check("R5 acks per held cycle", 64'(n_ack), 64'd3);
        check("R5 consecutive", 64'(last_i - first_i), 64'd2);
        check("R6 status occ3", cap[0], exp_stat(3));
        check("R6 status occ3 last", cap[2], exp_stat(3));
        for (int k = 0; k < DEP + 1; k++) push(2);
        probe_status("R10 full drop R6", 2);
    endtask

    task automatic t_single_late;
        select(1);
        run_req(4, 0, 0);
        check("R3 one ack for held req R8", 64'(n_ack), 64'd1);
        check("R3 ack in first cycle", 64'(first_i), 64'd0);
        check("R3 data", cap[0], mkdata(1, head[1]));
        head[1]++;
        probe_status("R3", 1);
    endtask

    task automatic t_burst;
        select(2);
        run_req(1, 1, 0);
        check("R4 burst acks", 64'(n_ack), 64'(BL));
        check("R4 consecutive", 64'(last_i - first_i), 64'(BL - 1));
        for (int k = 0; k < BL; k++) check("R4 burst order", cap[k], mkdata(2, head[2] + k));
        head[2] += BL;
        probe_status("R4", 2);
        select(2);
        run_req(7, 1, 0);
        check("R8 held burst acks", 64'(n_ack), 64'(BL));
        check("R4 held burst first", cap[0], mkdata(2, head[2]));
        head[2] += BL;
        probe_status("R8", 2);
    endtask

    task automatic t_empty;
        select(0);
        run_req(1, 0, 0);
        check("R7 err_ack on empty", 64'(n_err), 64'd1);
        check("R7 no ack on empty", 64'(n_ack), 64'd0);
        probe_status("R7", 0);
        push(0);
        select(0);
        run_req(1, 0, 0);
        check("R7 pointers kept", cap[0], mkdata(0, 0));
        head[0]++;
        for (int k = 0; k < 2; k++) push(3);
        select(3);
        run_req(1, 1, 0);
        check("R7 short burst acks", 64'(n_ack), 64'd2);
        check("R7 short burst err", 64'(n_err), 64'd1);
        head[3] += 2;
        probe_status("R7", 3);
    endtask

    task automatic t_indep;
        probe_status("R9", 1);
        select(1);
        run_req(1, 0, 0);
        check("R9 order kept", cap[0], mkdata(1, head[1]));
        head[1]++;
        probe_status("R9", 1);
        probe_status("R9", 2);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin head[c] = 0; tail[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        t_reset();
        t_chan_valid();
        t_status();
        t_single_late();
        t_burst();
        t_empty();
        t_indep();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule